// File: doc/BRIEF.md
# Compare-Match Timer with Collision Arbitration

This block is an up-counter with two compare channels that together shape a single waveform output. A host writes the counter, the two compare values and an overflow-clear strobe through a small write-only port. Each cycle of the system clock, the counter is tested against both compare values. A fresh match on a channel can reset the counter and can act on the output pin. The possible actions are to leave it, force it low, force it high or invert it.

The count source is one of several prescaled clock levels supplied from outside, or an external pin passed through a synchroniser. The source can also be stopped. The counter advances on a high-to-low transition of the chosen source level. That level is taken after the selector, so changing the selection from a high source to a low one is itself a count. When events land in the same system clock cycle, fixed precedence rules decide the result, so the outcome never depends on timing inside the cycle.

Top module: `cmt_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter becomes 0x00, both compare values become 0xFF, and `wave` and `ovf` become 0.
- R2: A host write (`wr_en`=1) with `wr_addr` 0 loads the counter, with 1 loads compare A and with 2 loads compare B. The new value takes effect from the next cycle.
- R3: `clk_sel` chooses the count source: 0 stopped, 1 `presc_clk[0]`, 2 `presc_clk[1]`, 3 external. The counter increments once for each 1-to-0 change of the chosen level. The external pin passes through two synchroniser flops and is inverted when `ext_rise`=1, so that its rising edges count. A fall on `ext_clk` therefore shows on `cnt` three cycles later.
- R4: Changing `clk_sel` from a source that is high to one that is low counts once. This holds for switches between two prescaled clocks and between a prescaled clock and the external pin.
- R5: A channel matches in the first cycle in which the counter equals its compare value while `tmr_en`=1. With `clr_mode` 1 a match on A clears the counter to 0x00 in the next cycle, and with `clr_mode` 2 a match on B does so. Values 0 and 3 never clear.
- R6: When a clear and a host counter write fall in the same cycle, the clear wins and the written value is discarded.
- R7: When a count and a host counter write fall in the same cycle, the written value is loaded and that count is lost.
- R8: A host write to a compare register suppresses that channel's match in the same cycle. The written value is used for matching from the next cycle.
- R9: A channel's action field (`act_a`, `act_b`) selects what a match does to `wave`: 0 leaves it, 1 drives 0, 2 drives 1, 3 inverts it. The change is visible in the cycle after the match.
- R10: When both channels match in one cycle, toggle takes priority over drive 1, and drive 1 takes priority over drive 0.
- R11: A count from 0xFF wraps the counter to 0x00 and sets `ovf`. `ovf` stays set until a write to `wr_addr` 3 with data bit 0 set. If a wrap and that clear fall in the same cycle, `ovf` stays set.
- R12: While `tmr_en`=0, counts and matches are ignored and `wave` follows `init_lvl` one cycle later. Host writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Write target: 0 counter, 1 compare A, 2 compare B, 3 overflow clear |
| wr_data | input | 8 | Write data |
| tmr_en | input | 1 | Timer enable |
| init_lvl | input | 1 | Level loaded onto `wave` while disabled |
| clk_sel | input | 2 | Count source selection |
| ext_rise | input | 1 | External pin counts on rising edges when 1 |
| clr_mode | input | 2 | Counter clear source: 1 match A, 2 match B, else none |
| act_a | input | 2 | Output action on match A |
| act_b | input | 2 | Output action on match B |
| presc_clk | input | 2 | Prescaled clock levels, synchronous to `clk` |
| ext_clk | input | 1 | Asynchronous external count pin |
| cnt | output | 8 | Counter value |
| ovf | output | 1 | Sticky overflow flag |
| wave | output | 1 | Waveform output |

## Verification
Assertions check the following on every cycle:
- The precedence inside the counter: a clear beats a write, and a write beats a count.
- That a disabled counter holds its value.
- That `ovf` only rises after the counter held 0xFF.
- That a written compare value lands, and that a channel never matches in two consecutive cycles.
- That `wave` obeys the toggle, high, low order and the disabled load.

Some behaviour only the bench scenarios can show, by comparing against a reference model on every clock:
- The source-switch count and the three-cycle external latency.
- The suppression of a match by a compare write in the same cycle, seen on `wave` afterwards.
- The survival of `ovf` when a wrap meets a clear.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the compare-match timer.
package cmt_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        CLR_NONE   = 2'b00,
        CLR_ON_A   = 2'b01,
        CLR_ON_B   = 2'b10,
        CLR_NONE_X = 2'b11
    } clr_e;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CMPA = 2'd1;
    localparam logic [1:0] ADDR_CMPB = 2'd2;
    localparam logic [1:0] ADDR_OVF  = 2'd3;
endpackage

// File: rtl/cmt_clk_src.sv
`timescale 1ns/1ps
// Count source selection and falling-edge detection.
// The edge is detected on the level after the selector, so a selection change
// from high to low is a count. Assumes presc_clk is synchronous to clk.
module cmt_clk_src #(
    parameter int N_PRESC     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_PRESC + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PRESC-1:0] presc_clk,
    input  logic               ext_clk,
    input  logic               ext_rise,
    input  logic [SEL_W-1:0]   clk_sel,
    output logic               tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_lvl;
    logic                   sel_now;
    logic                   sel_q;

    // Purpose: bring the asynchronous pin into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
    end

    assign ext_lvl = sync_q[SYNC_STAGES-1] ^ ext_rise;

    // Purpose: pick the level of the selected source (0 = stopped).
    always_comb begin
        sel_now = 1'b0;
        for (int i = 0; i < N_PRESC; i++) begin
            if (clk_sel == SEL_W'(i + 1)) sel_now = presc_clk[i];
        end
        if (clk_sel == SEL_W'(N_PRESC + 1)) sel_now = ext_lvl;
    end

    // Purpose: remember the previous selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_now;
    end

    assign tick = sel_q & ~sel_now;

    p_stopped_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == '0 && $past(clk_sel) == '0) |-> !tick);
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
// Up-counter with the precedence clear > host write > count, plus a sticky
// overflow flag with write-one-to-clear (a wrap in the same cycle wins).
module cmt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         clr,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    input  logic         ovf_w1c,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic wrap;

    assign wrap = en & tick & ~clr & ~wr_cnt & (cnt == '1);

    // Purpose: counter update in fixed precedence order.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (wr_cnt)    cnt <= wr_data;
        else if (en && tick) cnt <= cnt + 1'b1;
    end

    // Purpose: sticky overflow flag, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (ovf_w1c) ovf <= 1'b0;
    end

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && wr_cnt) |=> cnt == '0);
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !clr && en && tick) |=> cnt == $past(wr_data));
    p_ovf_after_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(cnt) == '1);
    p_hold_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr && !wr_cnt) |=> $stable(cnt));
endmodule

// File: rtl/cmt_cmp_chan.sv
`timescale 1ns/1ps
// One compare channel: holds its compare value and flags a match in the first
// cycle of equality with the counter. A write to the channel masks that cycle.
module cmt_cmp_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    output logic         match
);
    logic [W-1:0] cmp_q;
    logic         eq;
    logic         eq_q;

    // Purpose: compare register, loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)  cmp_q <= '1;
        else if (wr) cmp_q <= wr_data;
    end

    assign eq = (cnt == cmp_q);

    // Purpose: remember last cycle's equality so only its onset matches.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    assign match = en & eq & ~eq_q & ~wr;

    p_cmp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cmp_q == $past(wr_data));
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
endmodule

// File: rtl/cmt_wave.sv
`timescale 1ns/1ps
// Resolves the actions of both channels onto the output pin.
// Priority: toggle, then drive high, then drive low. Disabled: load init level.
module cmt_wave
    import cmt_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            init_lvl,
    input  logic [N_CH-1:0] match,
    input  act_e            act [N_CH],
    output logic            wave
);
    logic any_tgl, any_hi, any_lo;

    // Purpose: collect the requested actions of matching channels.
    always_comb begin
        any_tgl = 1'b0;
        any_hi  = 1'b0;
        any_lo  = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            if (match[c]) begin
                any_tgl = any_tgl | (act[c] == ACT_TOGGLE);
                any_hi  = any_hi  | (act[c] == ACT_HIGH);
                any_lo  = any_lo  | (act[c] == ACT_LOW);
            end
        end
    end

    // Purpose: output register with the action priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       wave <= 1'b0;
        else if (!en)     wave <= init_lvl;
        else if (any_tgl) wave <= ~wave;
        else if (any_hi)  wave <= 1'b1;
        else if (any_lo)  wave <= 1'b0;
    end

    p_toggle_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && any_tgl) |=> wave != $past(wave));
    p_high_over_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !any_tgl && any_hi) |=> wave);
    p_init_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> wave == $past(init_lvl));
endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
// Compare-match timer top: count source, counter, two compare channels and
// the waveform output. All inputs are assumed synchronous to clk except ext_clk.
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int W           = 8,
    parameter int N_PRESC     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_PRESC + 2),
    localparam int N_CH       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [W-1:0]       wr_data,
    input  logic               tmr_en,
    input  logic               init_lvl,
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic               ext_rise,
    input  logic [1:0]         clr_mode,
    input  logic [1:0]         act_a,
    input  logic [1:0]         act_b,
    input  logic [N_PRESC-1:0] presc_clk,
    input  logic               ext_clk,
    output logic [W-1:0]       cnt,
    output logic               ovf,
    output logic               wave
);
    logic            tick;
    logic            clr;
    logic [N_CH-1:0] match;
    logic [N_CH-1:0] wr_cmp;
    act_e            act [N_CH];
    clr_e            cmode;

    assign act[0] = act_e'(act_a);
    assign act[1] = act_e'(act_b);
    assign cmode  = clr_e'(clr_mode);
    assign wr_cmp[0] = wr_en && (wr_addr == ADDR_CMPA);
    assign wr_cmp[1] = wr_en && (wr_addr == ADDR_CMPB);
    assign clr = ((cmode == CLR_ON_A) && match[0]) || ((cmode == CLR_ON_B) && match[1]);

    cmt_clk_src #(.N_PRESC(N_PRESC), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .presc_clk(presc_clk), .ext_clk(ext_clk),
        .ext_rise(ext_rise), .clk_sel(clk_sel), .tick(tick)
    );

    cmt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .tick(tick), .clr(clr),
        .wr_cnt(wr_en && (wr_addr == ADDR_CNT)), .wr_data(wr_data),
        .ovf_w1c(wr_en && (wr_addr == ADDR_OVF) && wr_data[0]),
        .cnt(cnt), .ovf(ovf)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        cmt_cmp_chan #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(tmr_en), .wr(wr_cmp[c]),
            .wr_data(wr_data), .cnt(cnt), .match(match[c])
        );
    end

    cmt_wave #(.N_CH(N_CH)) u_wave (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .init_lvl(init_lvl),
        .match(match), .act(act), .wave(wave)
    );

    p_clear_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: tb/cmt_timer_tb_top.sv
`timescale 1ns/1ps
module cmt_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tmr_en = 1'b0;
    logic       init_lvl = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       ext_rise = 1'b0;
    logic [1:0] clr_mode = 2'd0;
    logic [1:0] act_a = 2'd0;
    logic [1:0] act_b = 2'd0;
    logic [1:0] presc_clk = 2'd0;
    logic       ext_clk = 1'b0;
    logic [7:0] cnt;
    logic       ovf;
    logic       wave;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    cmt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_en(tmr_en), .init_lvl(init_lvl),
        .clk_sel(clk_sel), .ext_rise(ext_rise), .clr_mode(clr_mode),
        .act_a(act_a), .act_b(act_b), .presc_clk(presc_clk),
        .ext_clk(ext_clk), .cnt(cnt), .ovf(ovf), .wave(wave)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model, updated behaviourally at each rising edge.
    int m_cnt = 0, m_ca = 255, m_cb = 255, m_wave = 0, m_ovf = 0;
    int m_s1 = 0, m_s2 = 0, m_selq = 0, m_eqa = 0, m_eqb = 0;

    always @(posedge clk) begin
        int sel, tk, wc, wa, wb, wo, ea, eb, ma, mb, cl, wrp, tg, hi, lo;
        if (!rst_n) begin
            m_cnt = 0; m_ca = 255; m_cb = 255; m_wave = 0; m_ovf = 0;
            m_s1 = 0; m_s2 = 0; m_selq = 0; m_eqa = 0; m_eqb = 0;
        end else begin
            case (clk_sel)
                2'd1:    sel = presc_clk[0];
                2'd2:    sel = presc_clk[1];
                2'd3:    sel = m_s2 ^ int'(ext_rise);
                default: sel = 0;
            endcase
            tk = (m_selq == 1 && sel == 0) ? 1 : 0;
            wc = (wr_en && wr_addr == 2'd0) ? 1 : 0;
            wa = (wr_en && wr_addr == 2'd1) ? 1 : 0;
            wb = (wr_en && wr_addr == 2'd2) ? 1 : 0;
            wo = (wr_en && wr_addr == 2'd3 && wr_data[0]) ? 1 : 0;
            ea = (m_cnt == m_ca) ? 1 : 0;
            eb = (m_cnt == m_cb) ? 1 : 0;
            ma = (tmr_en && ea == 1 && m_eqa == 0 && wa == 0) ? 1 : 0;
            mb = (tmr_en && eb == 1 && m_eqb == 0 && wb == 0) ? 1 : 0;
            cl = ((clr_mode == 2'd1 && ma == 1) || (clr_mode == 2'd2 && mb == 1)) ? 1 : 0;
            wrp = (tmr_en && tk == 1 && cl == 0 && wc == 0 && m_cnt == 255) ? 1 : 0;
            tg = ((ma == 1 && act_a == 2'd3) || (mb == 1 && act_b == 2'd3)) ? 1 : 0;
            hi = ((ma == 1 && act_a == 2'd2) || (mb == 1 && act_b == 2'd2)) ? 1 : 0;
            lo = ((ma == 1 && act_a == 2'd1) || (mb == 1 && act_b == 2'd1)) ? 1 : 0;
            if (cl == 1)                 m_cnt = 0;
            else if (wc == 1)            m_cnt = int'(wr_data);
            else if (tmr_en && tk == 1)  m_cnt = (m_cnt + 1) % 256;
            if (wrp == 1)      m_ovf = 1;
            else if (wo == 1)  m_ovf = 0;
            if (!tmr_en)       m_wave = int'(init_lvl);
            else if (tg == 1)  m_wave = 1 - m_wave;
            else if (hi == 1)  m_wave = 1;
            else if (lo == 1)  m_wave = 0;
            if (wa == 1) m_ca = int'(wr_data);
            if (wb == 1) m_cb = int'(wr_data);
            m_eqa = ea; m_eqb = eb; m_selq = sel;
            m_s2 = m_s1; m_s1 = int'(ext_clk);
        end
    end

    // Per-cycle comparison against the model, plus the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk(cur_req, "model cnt", int'(cnt), m_cnt);
            chk(cur_req, "model wave", int'(wave), m_wave);
            chk(cur_req, "model ovf", int'(ovf), m_ovf);
        end
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse0();
        presc_clk[0] = 1'b1; cyc(1);
        presc_clk[0] = 1'b0; cyc(1);
    endtask

    task automatic rearm_a();
        wr(2'd0, 8'h00); wr(2'd0, 8'h20); cyc(1);
    endtask

    initial begin
        cyc(3);
        cur_req = "R1";
        chk("R1", "reset cnt", int'(cnt), 0);
        chk("R1", "reset wave", int'(wave), 0);
        chk("R1", "reset ovf", int'(ovf), 0);
        rst_n = 1'b1; tmr_en = 1'b1;
        cyc(1);

        cur_req = "R2";
        wr(2'd0, 8'h42);
        chk("R2", "counter write", int'(cnt), 'h42);

        cur_req = "R3";
        clk_sel = 2'd1;
        pulse0();
        chk("R3", "prescaled fall", int'(cnt), 'h43);
        for (int i = 0; i < 3; i++) pulse0();
        chk("R3", "three more falls", int'(cnt), 'h46);

        cur_req = "R4";
        presc_clk = 2'b01; cyc(1);
        clk_sel = 2'd2; cyc(1);
        chk("R4", "switch p0 high to p1 low", int'(cnt), 'h47);
        presc_clk = 2'b10; cyc(1);
        clk_sel = 2'd3; cyc(1);
        chk("R4", "switch p1 high to ext low", int'(cnt), 'h48);

        cur_req = "R3";
        ext_clk = 1'b1; cyc(4);
        chk("R3", "ext rise ignored", int'(cnt), 'h48);
        ext_clk = 1'b0; cyc(2);
        chk("R3", "ext sync latency", int'(cnt), 'h48);
        cyc(1);
        chk("R3", "ext fall counted", int'(cnt), 'h49);
        ext_rise = 1'b1; cyc(2);
        ext_clk = 1'b1; cyc(3);
        chk("R3", "ext rise polarity", int'(cnt), 'h4A);
        clk_sel = 2'd0; presc_clk = 2'b00; cyc(1);

        cur_req = "R6";
        wr(2'd1, 8'h10);
        clr_mode = 2'd1;
        wr(2'd0, 8'h10);
        wr(2'd0, 8'h33);
        chk("R6", "clear beats write", int'(cnt), 0);

        cur_req = "R5";
        clk_sel = 2'd1;
        wr(2'd0, 8'h0E);
        pulse0(); pulse0();
        chk("R5", "counted to compare", int'(cnt), 'h10);
        cyc(1);
        chk("R5", "clear on A", int'(cnt), 0);
        clr_mode = 2'd2;
        wr(2'd2, 8'h07); wr(2'd0, 8'h07); cyc(1);
        chk("R5", "clear on B", int'(cnt), 0);
        clr_mode = 2'd0;
        wr(2'd0, 8'h07); cyc(2);
        chk("R5", "no clear mode", int'(cnt), 7);

        cur_req = "R7";
        presc_clk[0] = 1'b1; cyc(1);
        presc_clk[0] = 1'b0;
        wr(2'd0, 8'h80);
        chk("R7", "write beats count", int'(cnt), 'h80);

        cur_req = "R8";
        act_a = 2'd3;
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h20);
        chk("R8", "match masked by compare write", int'(wave), 0);
        cyc(1);
        chk("R8", "still masked", int'(wave), 0);
        wr(2'd0, 8'h20); cyc(1);
        chk("R8", "new compare value used", int'(wave), 1);

        cur_req = "R9";
        act_a = 2'd1; rearm_a();
        chk("R9", "drive 0", int'(wave), 0);
        act_a = 2'd2; rearm_a();
        chk("R9", "drive 1", int'(wave), 1);
        act_a = 2'd0; rearm_a();
        chk("R9", "no change", int'(wave), 1);

        cur_req = "R10";
        wr(2'd2, 8'h20);
        act_a = 2'd1; act_b = 2'd0; rearm_a();
        chk("R10", "setup low", int'(wave), 0);
        act_a = 2'd1; act_b = 2'd2; rearm_a();
        chk("R10", "high beats low", int'(wave), 1);
        act_a = 2'd2; act_b = 2'd3; rearm_a();
        chk("R10", "toggle beats high", int'(wave), 0);
        act_a = 2'd0; act_b = 2'd0;

        cur_req = "R11";
        wr(2'd0, 8'hFF); pulse0();
        chk("R11", "wrap value", int'(cnt), 0);
        chk("R11", "ovf set", int'(ovf), 1);
        wr(2'd3, 8'h01);
        chk("R11", "ovf w1c", int'(ovf), 0);
        wr(2'd0, 8'hFF);
        presc_clk[0] = 1'b1; cyc(1);
        presc_clk[0] = 1'b0;
        wr(2'd3, 8'h01);
        chk("R11", "set beats clear", int'(ovf), 1);
        wr(2'd3, 8'h00);
        chk("R11", "bit0 clear needed", int'(ovf), 1);
        wr(2'd3, 8'h01);

        cur_req = "R12";
        init_lvl = 1'b1; tmr_en = 1'b0; cyc(1);
        chk("R12", "init level loaded", int'(wave), 1);
        wr(2'd0, 8'h55); pulse0();
        chk("R12", "count ignored", int'(cnt), 'h55);
        act_a = 2'd1;
        wr(2'd0, 8'h20); cyc(1);
        chk("R12", "match ignored", int'(wave), 1);
        tmr_en = 1'b1; cyc(2);
        chk("R12", "no stale match", int'(wave), 1);

        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom);
            presc_clk = r[1:0];
            ext_clk = r[2];
            if (r[7:4] == 4'd0) clk_sel = r[9:8];
            if (r[15:12] == 4'd0) begin act_a = r[17:16]; act_b = r[19:18]; end
            if (r[23:20] == 4'd0) clr_mode = r[25:24];
            wr_en = (r[28:26] == 3'd0);
            wr_addr = r[30:29];
            wr_data = {4'h2, r[11:10], r[27:26]};
            cyc(1);
        end
        wr_en = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule